// File: doc/BRIEF.md
# Gated Serial Clock Divider with Stop Handshake

This block derives the serial flash clock from the system clock through a power-of-two divider. Software can switch the internal serial clock on and off safely. The clock runs whenever either of two enable inputs is set: a main enable and a boot-path enable. It stops only when both are clear. A stop is not immediate. While the transfer sequencer reports busy, the stop waits. Once the sequencer is idle, the stop still waits for the end of the current serial period, so the clock is always parked at its low idle level and never emits a shortened pulse.

Two status bits support the configuration handshake. The first reports that the clock has really stopped. The second is a registered copy of the sequencer's idle state. A third output is high only when both are set, and marks the window in which software may change the configuration. The divider code and the phase select are sampled only while the clock is stopped, so writing them during a run cannot disturb the clock. The phase select accepts both settings, but the 90-degree setting produces exactly the same timing as the 180-degree one.

The divided clock appears in two forms. The first is a level output with a 50 percent duty cycle for the divided ratios; at ratio 1 it is a pass-through qualifier. The second is a one-cycle enable strobe in the last system cycle of every serial period.

Top module: `sclk_gated_div`

## Requirements
- R1: After reset, `clk_stopped`=1, `eng_idle`=1, `cfg_safe`=1, `sck_lvl`=0 and `sck_ce`=0. The sampled divider code is 0.
- R2: The sampled `div_code` value c (0 to 3) selects a serial period of 2^c system cycles. While running, `sck_ce` is high in exactly the last cycle of each period, so it is high every cycle at code 0.
- R3: For codes 1 to 3, `sck_lvl` is low for the first half of each period and high for the second half. For code 0 it is high on every running cycle. It is 0 whenever the clock is stopped.
- R4: The clock starts on the edge after `clk_en` or `boot_en` is seen high. It keeps running while either bit is set.
- R5: With both enables clear, the clock stops only on an edge where `eng_busy` is low and the current period ends. While `eng_busy` is high, it keeps running.
- R6: `clk_stopped` rises one edge after the clock stops and falls one edge after the clock starts.
- R7: `eng_idle` is `eng_busy` inverted and delayed by one edge. `cfg_safe` is high only when `clk_stopped` and `eng_idle` are both high.
- R8: `div_code` and `phase_sel` are sampled only while the clock is stopped. Changes made while it runs have no effect until the clock has stopped. Every start begins at the first cycle of a period.
- R9: `phase_sel`=1 (90 degrees) gives the same `sck_lvl` and `sck_ce` as `phase_sel`=0 (180 degrees).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Main serial clock enable |
| boot_en | input | 1 | Boot-path serial clock enable |
| phase_sel | input | 1 | Phase select: 0 = 180 degrees, 1 = 90 degrees |
| div_code | input | DIVW | Divider code; the ratio is 2^code |
| eng_busy | input | 1 | Transfer sequencer busy |
| sck_lvl | output | 1 | Divided serial clock level |
| sck_ce | output | 1 | Strobe in the last cycle of each serial period |
| clk_stopped | output | 1 | The serial clock is stopped |
| eng_idle | output | 1 | Registered idle state of the sequencer |
| cfg_safe | output | 1 | Configuration may be changed |

## Verification
The bench builds the block with the default DIVW of 2. This makes all four ratios (1, 2, 4 and 8) reachable, and an 8-cycle period fits inside a 32-cycle measuring window many times over. A cycle-accurate expectation of every output runs beside the design, so the exact stop edge is checked and not only the final state. Under busy hold-off, a divider change during a run and the 90-degree setting, that edge must fall on a period boundary.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  typedef enum logic {
    PH_DEG180 = 1'b0,
    PH_DEG90  = 1'b1
  } phase_e;

  // Serial period length in system cycles for a divider code.
  function automatic int unsigned ratio_of(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // True in the final system cycle of a serial period.
  function automatic logic at_last(input int unsigned pos, input int unsigned code);
    return pos == (ratio_of(code) - 32'd1);
  endfunction

  // Level of the divided clock at a given position within its period.
  function automatic logic high_half(input int unsigned pos, input int unsigned code);
    if (ratio_of(code) == 32'd1) return 1'b1;
    return pos >= (ratio_of(code) >> 1);
  endfunction

endpackage

// File: rtl/sclk_gate_ctrl.sv
module sclk_gate_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_any,
  input  logic eng_busy,
  input  logic period_end,
  output logic run,
  output logic stopped,
  output logic stop_fire
);

  // A stop may only land at the end of a period with the engine idle.
  assign stop_fire = run & ~en_any & ~eng_busy & period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      stopped <= 1'b1;
    end else begin
      if (en_any)         run <= 1'b1;
      else if (stop_fire) run <= 1'b0;
      stopped <= ~run;
    end
  end

endmodule

// File: rtl/sclk_div_core.sv
module sclk_div_core #(
  parameter int DIVW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div_code,
  input  logic            phase_sel,
  output logic [DIVW-1:0] div_q,
  output logic            period_end,
  output logic            sck_lvl,
  output logic            sck_ce
);
  import sclk_pkg::*;

  localparam int CNTW = (1 << DIVW) - 1;

  logic [CNTW-1:0] cnt;
  phase_e          phase_q;
  logic            lvl_base;
  int unsigned     pos;
  int unsigned     code;

  assign pos  = 32'(cnt);
  assign code = 32'(div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_q   <= '0;
      phase_q <= PH_DEG180;
    end else if (!run) begin
      cnt     <= '0;
      div_q   <= div_code;
      phase_q <= phase_e'(phase_sel);
    end else if (period_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign period_end = at_last(pos, code);
  assign lvl_base   = run & high_half(pos, code);
  assign sck_ce     = run & period_end;

  // The 90-degree arm is mapped onto the 180-degree timing.
  assign sck_lvl = (phase_q == PH_DEG90) ? lvl_base : lvl_base;

endmodule

// File: rtl/sclk_status.sv
module sclk_status (
  input  logic clk,
  input  logic rst_n,
  input  logic eng_busy,
  input  logic stopped,
  output logic eng_idle,
  output logic cfg_safe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eng_idle <= 1'b1;
    else        eng_idle <= ~eng_busy;
  end

  assign cfg_safe = stopped & eng_idle;

endmodule

// File: rtl/sclk_gated_div.sv
module sclk_gated_div #(
  parameter int DIVW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  logic            boot_en,
  input  logic            phase_sel,
  input  logic [DIVW-1:0] div_code,
  input  logic            eng_busy,
  output logic            sck_lvl,
  output logic            sck_ce,
  output logic            clk_stopped,
  output logic            eng_idle,
  output logic            cfg_safe
);

  logic            en_any;
  logic            run;
  logic            stop_fire;
  logic            period_end;
  logic [DIVW-1:0] div_q;

  assign en_any = clk_en | boot_en;

  sclk_gate_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_any     (en_any),
    .eng_busy   (eng_busy),
    .period_end (period_end),
    .run        (run),
    .stopped    (clk_stopped),
    .stop_fire  (stop_fire)
  );

  sclk_div_core #(.DIVW(DIVW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .div_code   (div_code),
    .phase_sel  (phase_sel),
    .div_q      (div_q),
    .period_end (period_end),
    .sck_lvl    (sck_lvl),
    .sck_ce     (sck_ce)
  );

  sclk_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .eng_busy (eng_busy),
    .stopped  (clk_stopped),
    .eng_idle (eng_idle),
    .cfg_safe (cfg_safe)
  );

endmodule

// File: rtl/sclk_gated_div_chk.sv
module sclk_gated_div_chk #(
  parameter int DIVW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clk_en,
  input logic            boot_en,
  input logic            eng_busy,
  input logic            run,
  input logic            stopped,
  input logic            sck_lvl,
  input logic            sck_ce,
  input logic [DIVW-1:0] div_q
);

  a_r4_enable_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en || boot_en) |=> run);

  a_r5_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (run && eng_busy) |=> run);

  a_r6_stop_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |=> stopped);

  a_r6_start_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |=> !stopped);

  a_r3_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sck_lvl);

  a_r2_strobe_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    sck_ce |-> run);

  a_r8_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(div_q));

endmodule

bind sclk_gated_div sclk_gated_div_chk #(.DIVW(DIVW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_en   (clk_en),
  .boot_en  (boot_en),
  .eng_busy (eng_busy),
  .run      (run),
  .stopped  (clk_stopped),
  .sck_lvl  (sck_lvl),
  .sck_ce   (sck_ce),
  .div_q    (div_q)
);

// File: tb/sim_sclk_gated_div.sv
`timescale 1ns/100ps
module sim_sclk_gated_div;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0, boot_en = 1'b0, phase_sel = 1'b0, eng_busy = 1'b0;
  logic [1:0] div_code = 2'd0;
  logic       sck_lvl, sck_ce, clk_stopped, eng_idle, cfg_safe;

  int checks = 0;
  int errors = 0;
  int ce_seen = 0;
  int lvl_seen = 0;
  bit done = 1'b0;

  typedef struct { bit ce; bit lvl; bit stp; bit idl; bit safe; } exp_t;
  exp_t sb[$];

  // Expectation state, advanced one edge per driven cycle.
  bit m_run = 0, m_stp = 1, m_idle = 1;
  int m_div = 0, m_pos = 0;

  always #2 clk = ~clk;

  sclk_gated_div u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .boot_en(boot_en),
    .phase_sel(phase_sel), .div_code(div_code), .eng_busy(eng_busy),
    .sck_lvl(sck_lvl), .sck_ce(sck_ce), .clk_stopped(clk_stopped),
    .eng_idle(eng_idle), .cfg_safe(cfg_safe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of inputs and predict the state after the edge.
  task automatic drive(input bit en, input bit bt, input int code, input bit ph, input bit bs);
    int  per;
    bit  nrun;
    int  npos;
    int  ndiv;
    exp_t e;
    @(negedge clk);
    clk_en = en; boot_en = bt; div_code = 2'(code); phase_sel = ph; eng_busy = bs;
    per  = 1 << m_div;
    nrun = m_run;
    if (en || bt) nrun = 1;
    else if (m_run && !bs && (m_pos % per == per - 1)) nrun = 0;
    npos = (m_run && nrun) ? (m_pos + 1) % per : 0;
    ndiv = m_run ? m_div : code;
    m_stp = !m_run; m_idle = !bs; m_run = nrun; m_pos = npos; m_div = ndiv;
    per    = 1 << m_div;
    e.ce   = m_run && (m_pos == per - 1);
    e.lvl  = m_run && ((per == 1) || (2 * m_pos >= per));
    e.stp  = m_stp;
    e.idl  = m_idle;
    e.safe = m_stp && m_idle;
    sb.push_back(e);
  endtask

  // Monitor: compare one predicted item per edge, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk("R2 sck_ce", int'(sck_ce), int'(e.ce));
        chk("R3 sck_lvl", int'(sck_lvl), int'(e.lvl));
        chk("R6 clk_stopped", int'(clk_stopped), int'(e.stp));
        chk("R7 eng_idle", int'(eng_idle), int'(e.idl));
        chk("R7 cfg_safe", int'(cfg_safe), int'(e.safe));
        ce_seen  += int'(sck_ce);
        lvl_seen += int'(sck_lvl);
      end
    end
  end

  task automatic settle();
    @(posedge clk);
    #1.5;
  endtask

  task automatic stop_clock(input int code);
    for (int i = 0; i < 20; i++) begin
      drive(0, 0, code, 0, 0);
      settle();
      if (clk_stopped) break;
    end
  endtask

  task automatic window(input bit en, input bit bt, input int code, input bit ph, input int n);
    ce_seen = 0; lvl_seen = 0;
    for (int i = 0; i < n; i++) drive(en, bt, code, ph, 0);
    settle();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1.5;
    // R1: reset values
    chk("R1 clk_stopped", int'(clk_stopped), 1);
    chk("R1 eng_idle", int'(eng_idle), 1);
    chk("R1 cfg_safe", int'(cfg_safe), 1);
    chk("R1 sck_lvl", int'(sck_lvl), 0);
    chk("R1 sck_ce", int'(sck_ce), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 / R3: every ratio over a 32-cycle window from a fresh start
    for (int c = 0; c < 4; c++) begin
      drive(0, 0, c, 0, 0);
      window(1, 0, c, 0, 32);
      chk("R2 strobes per window", ce_seen, 32 >> c);
      chk("R3 high cycles", lvl_seen, (c == 0) ? 32 : 16);
      stop_clock(c);
      chk("R3 parked low", int'(sck_lvl), 0);
    end

    // R6: flag clears one edge after the start edge
    drive(0, 0, 1, 0, 0);
    drive(1, 0, 1, 0, 0);
    settle();
    chk("R6 flag lags start", int'(clk_stopped), 1);
    drive(1, 0, 1, 0, 0);
    settle();
    chk("R6 flag cleared", int'(clk_stopped), 0);
    stop_clock(1);

    // R4: the boot-path enable alone runs the clock; main off, boot on keeps it
    window(0, 1, 1, 0, 10);
    chk("R4 boot enable runs", int'(clk_stopped), 0);
    window(1, 1, 1, 0, 4);
    window(0, 1, 1, 0, 6);
    chk("R4 one enable still runs", int'(clk_stopped), 0);
    stop_clock(1);
    chk("R4 both clear stops", int'(clk_stopped), 1);

    // R5: a busy engine holds the clock off its stop
    window(1, 0, 2, 0, 3);
    for (int i = 0; i < 20; i++) drive(0, 0, 2, 0, 1);
    settle();
    chk("R5 held by busy", int'(clk_stopped), 0);
    stop_clock(2);
    chk("R5 stops after idle", int'(clk_stopped), 1);

    // R7: busy while stopped blocks the safe window
    drive(0, 0, 2, 0, 1);
    settle();
    chk("R7 busy blocks safe", int'(cfg_safe), 0);
    drive(0, 0, 2, 0, 0);
    settle();
    chk("R7 safe restored", int'(cfg_safe), 1);

    // R8: code change during a run is ignored
    drive(0, 0, 1, 0, 0);
    window(1, 0, 1, 0, 4);
    window(1, 0, 3, 0, 16);
    chk("R8 old ratio kept", ce_seen, 8);
    stop_clock(3);
    drive(0, 0, 3, 0, 0);
    window(1, 0, 3, 0, 32);
    chk("R8 new ratio after stop", ce_seen, 4);
    stop_clock(3);

    // R9: 90-degree setting gives identical timing
    drive(0, 0, 2, 1, 0);
    window(1, 0, 2, 1, 32);
    chk("R9 strobes", ce_seen, 8);
    chk("R9 high cycles", lvl_seen, 16);
    stop_clock(2);

    repeat (3) settle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule